// File: doc/BRIEF.md
# DRAM Command Spacing Timing Guard

This block sits between a DRAM command scheduler and the command port of the physical layer. It holds back a command until four minimum-spacing rules allow it:

- the rolling four-activate window;
- the load-mode cycle time, which governs the gap after a mode-register load to any following command;
- the load-mode update delay, which governs the gap after a mode-register load to the next command of another kind;
- the write-leveling delay, which governs the gap after a mode-register load that enables write leveling to the first leveling strobe request.

All spacing is counted in controller clock cycles. A spacing of N means that a command accepted at edge e lets a gated command be accepted at edge e+N at the earliest.

A 32-bit configuration word carries the timing fields. A two-bit memory-type input selects how the fields are decoded:

| Type | Code | Load-mode cycle time | Update delay |
|------|------|----------------------|--------------|
| DDR3 | 0 | field + 4 | codes 0..5 give 12..17, codes 6 and 7 give 17 |
| DDR4 | 1 | field + 8 | codes 0..6 give 24..30, code 7 gives 30 |
| LPDDR3 | 2 | field + 8 | rule not applied |
| LPDDR4 | 3 | field + 0 | rule not applied |

The scheduler offers commands on a valid/ready interface. While `req_valid` is high and `req_ready` is low, the scheduler must hold `req_op` steady. A command is accepted on a clock edge where both are high. `req_ready` is a combinational function of `req_op` and the block's internal state, and it does not depend on `req_valid`. An accepted command appears one cycle later as a single-cycle pulse on `iss_valid`, with its opcode on `iss_op`.

Top module: `cmd_spacing_guard`

## Requirements
- R1: After synchronous reset, `iss_valid` is low and every opcode sees `req_ready` high, so the first command is never stalled.
- R2: After a load-mode command (opcode 2 or 3) is accepted at edge e, no command is accepted before edge e+M. M is configuration bits 4:0 plus 4 for DDR3, plus 8 for DDR4 and LPDDR3, and plus 0 for LPDDR4. Memory-type codes are DDR3=0, DDR4=1, LPDDR3=2, LPDDR4=3.
- R3: For DDR4, after a load-mode command at edge e, a command that is not a load-mode command waits until edge e+D. D is 24 plus the update code in bits 10:8, with the code capped at 6.
- R4: For DDR3, the update delay D is 12 plus the code, with the code capped at 5. For LPDDR3 and LPDDR4 the update-delay rule does not constrain any command.
- R5: With `eight_bank` high, an activate (opcode 1) is accepted at edge t only if fewer than four activates have been accepted, or the fourth-most-recent activate was accepted at edge t-W or earlier. W is configuration bits 22:16, valid from 2 to 127.
- R6: With `eight_bank` low, activates are not restricted by the four-activate rule.
- R7: After a load-mode command that enables write leveling (opcode 3) is accepted at edge e, a leveling strobe request (opcode 4) waits until edge e+L. L is configuration bits 30:24.
- R8: A command accepted at edge e produces `iss_valid` high with the same opcode for exactly the cycle after e. No pulse follows an edge without acceptance.
- R9: A new configuration word or memory type takes effect only once every spacing counter has expired and no command is being accepted. Spacings already running keep the values they were loaded with.
- R10: Configuration bits 31, 23, 15:11 and 7:5 are ignored. Opcodes 0, 5, 6 and 7 are ordinary commands that are gated only by R2 and by R3/R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Timing configuration word |
| mem_kind | input | 2 | Memory type: 0 DDR3, 1 DDR4, 2 LPDDR3, 3 LPDDR4 |
| eight_bank | input | 1 | High when the device has eight banks, which enables the activate window |
| req_valid | input | 1 | Scheduler offers a command |
| req_op | input | 3 | Opcode: 1 activate, 2 load-mode, 3 load-mode enabling write leveling, 4 leveling strobe request, others ordinary |
| req_ready | output | 1 | Offered opcode may be accepted this cycle |
| iss_valid | output | 1 | One-cycle issue pulse toward the physical layer |
| iss_op | output | 3 | Opcode of the issued command |

## Verification
The main input patterns are listed below, and each one isolates a different rule:

- **Dense activate bursts with eight banks on and off:** these separate the four-activate window from an unbounded activate stream.
- **Load-mode commands followed by ordinary commands and by further load-mode commands:** these separate the update delay from the load-mode cycle time, and they show the per-type offsets and decode caps on all four memory types.
- **A write-leveling load followed by strobe requests under LPDDR4:** with zero offset and no update delay, the leveling delay is seen on its own.
- **A configuration change made while a spacing is running:** this shows that the old value still governs that spacing.

Random traffic is driven with held back-pressured requests and random reserved bits, and it is compared cycle by cycle against a timestamp model.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    MEM_DDR3   = 2'd0,
    MEM_DDR4   = 2'd1,
    MEM_LPDDR3 = 2'd2,
    MEM_LPDDR4 = 2'd3
  } mem_kind_e;

  localparam logic [2:0] OP_ACT       = 3'd1;
  localparam logic [2:0] OP_LDMODE    = 3'd2;
  localparam logic [2:0] OP_LDMODE_WL = 3'd3;
  localparam logic [2:0] OP_WL_STROBE = 3'd4;

  localparam int CFG_W  = 32;
  localparam int WIN_W  = 7;
  localparam int MRD_FW = 5;
  localparam int MRD_W  = MRD_FW + 1;
  localparam int MOD_W  = 5;

  typedef struct packed {
    logic [WIN_W-1:0]  wl_gap;
    logic [WIN_W-1:0]  act_win;
    logic [2:0]        upd_code;
    logic [MRD_FW-1:0] lm_gap;
  } cfg_fields_t;

  function automatic cfg_fields_t split_cfg(input logic [CFG_W-1:0] w);
    cfg_fields_t f;
    f.wl_gap   = w[30:24];
    f.act_win  = w[22:16];
    f.upd_code = w[10:8];
    f.lm_gap   = w[4:0];
    return f;
  endfunction

  function automatic logic [MRD_W-1:0] lm_gap_eff(input logic [MRD_FW-1:0] f,
                                                  input mem_kind_e k);
    logic [MRD_W-1:0] base;
    base = {1'b0, f};
    case (k)
      MEM_DDR3:            return base + MRD_W'(4);
      MEM_DDR4, MEM_LPDDR3: return base + MRD_W'(8);
      default:             return base;
    endcase
  endfunction

  function automatic logic [MOD_W-1:0] upd_gap_eff(input logic [2:0] c,
                                                   input mem_kind_e k);
    case (k)
      MEM_DDR4: return MOD_W'(24) + MOD_W'((c > 3'd6) ? 3'd6 : c);
      MEM_DDR3: return MOD_W'(12) + MOD_W'((c > 3'd5) ? 3'd5 : c);
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/guard_cfg_regs.sv
module guard_cfg_regs
  import guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_W-1:0]     cfg_word,
  input  logic [1:0]           mem_kind,
  input  logic                 quiet,
  output logic [MRD_W-1:0]     lm_n,
  output logic [MOD_W-1:0]     upd_n,
  output logic [WIN_W-1:0]     wl_n,
  output logic [WIN_W-1:0]     win_n
);

  logic [CFG_W-1:0] act_word;
  mem_kind_e        act_kind;
  cfg_fields_t      f;

  always_ff @(posedge clk) begin
    if (rst || quiet) begin
      act_word <= cfg_word;
      act_kind <= mem_kind_e'(mem_kind);
    end
  end

  always_comb begin
    f     = split_cfg(act_word);
    lm_n  = lm_gap_eff(f.lm_gap, act_kind);
    upd_n = upd_gap_eff(f.upd_code, act_kind);
    wl_n  = f.wl_gap;
    win_n = f.act_win;
  end

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !quiet |=> ($stable(act_word) && $stable(act_kind)));

endmodule

// File: rtl/guard_gap_ctr.sv
module guard_gap_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         clear
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= (span == '0) ? '0 : span - W'(1);
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign clear = (cnt == '0);

  // Covers R2, R3 and R7: a loaded gap longer than one cycle blocks the next cycle.
  p_load_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (load && span > W'(1)) |=> !clear);

endmodule

// File: rtl/guard_act_window.sv
module guard_act_window #(
  parameter int DEPTH = 4,
  parameter int AGE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             push,
  input  logic [AGE_W-1:0] window,
  output logic             ok
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age [DEPTH];
  logic [DEPTH-1:0] vld;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [AGE_W-1:0] base;
    logic             vnext;
    if (i == 0) begin : g_head
      assign base  = push ? '0 : age[0];
      assign vnext = push | vld[0];
    end else begin : g_tail
      assign base  = push ? age[i-1] : age[i];
      assign vnext = push ? vld[i-1] : vld[i];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        age[i] <= '0;
        vld[i] <= 1'b0;
      end else begin
        age[i] <= (base == AGE_MAX) ? AGE_MAX : base + AGE_W'(1);
        vld[i] <= vnext;
      end
    end
    p_entry_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      vld[i] |=> vld[i]);
    p_entry_aged_r5: assert property (@(posedge clk) disable iff (rst)
      vld[i] |-> age[i] != '0);
  end

  assign ok = !enable || !vld[DEPTH-1] || (age[DEPTH-1] >= window);

  p_push_records_r5: assert property (@(posedge clk) disable iff (rst)
    push |=> vld[0]);

endmodule

// File: rtl/cmd_spacing_guard.sv
module cmd_spacing_guard
  import guard_pkg::*;
#(
  parameter int ACT_LIMIT = 4,
  parameter int OP_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     cfg_word,
  input  logic [1:0]      mem_kind,
  input  logic            eight_bank,
  input  logic            req_valid,
  input  logic [OP_W-1:0] req_op,
  output logic            req_ready,
  output logic            iss_valid,
  output logic [OP_W-1:0] iss_op
);

  logic [MRD_W-1:0] lm_n;
  logic [MOD_W-1:0] upd_n;
  logic [WIN_W-1:0] wl_n;
  logic [WIN_W-1:0] win_n;
  logic             lm_clr, upd_clr, wl_clr, win_ok;
  logic             fire, is_lm, is_wl_lm, is_act, is_strobe, quiet;

  assign is_lm     = (req_op == OP_LDMODE) || (req_op == OP_LDMODE_WL);
  assign is_wl_lm  = (req_op == OP_LDMODE_WL);
  assign is_act    = (req_op == OP_ACT);
  assign is_strobe = (req_op == OP_WL_STROBE);

  assign req_ready = lm_clr
                   && (is_lm || upd_clr)
                   && (!is_strobe || wl_clr)
                   && (!is_act || win_ok);
  assign fire  = req_valid && req_ready;
  assign quiet = lm_clr && upd_clr && wl_clr && !fire;

  guard_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .mem_kind(mem_kind),
    .quiet(quiet), .lm_n(lm_n), .upd_n(upd_n), .wl_n(wl_n), .win_n(win_n)
  );

  guard_gap_ctr #(.W(MRD_W)) u_lm_gap (
    .clk(clk), .rst(rst), .load(fire && is_lm), .span(lm_n), .clear(lm_clr)
  );

  guard_gap_ctr #(.W(MOD_W)) u_upd_gap (
    .clk(clk), .rst(rst), .load(fire && is_lm), .span(upd_n), .clear(upd_clr)
  );

  guard_gap_ctr #(.W(WIN_W)) u_wl_gap (
    .clk(clk), .rst(rst), .load(fire && is_wl_lm), .span(wl_n), .clear(wl_clr)
  );

  guard_act_window #(.DEPTH(ACT_LIMIT), .AGE_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .enable(eight_bank), .push(fire && is_act),
    .window(win_n), .ok(win_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_op    <= '0;
    end else begin
      iss_valid <= fire;
      iss_op    <= fire ? req_op : iss_op;
    end
  end

  p_issue_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> (iss_valid && iss_op == $past(req_op)));

  p_idle_no_issue_r8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !iss_valid);

  p_lm_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && is_lm && lm_n > MRD_W'(1)) |=> !req_ready);

  p_strobe_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && is_wl_lm && wl_n > WIN_W'(1)) |=> !(is_strobe && req_ready));

endmodule

// File: tb/cmd_spacing_guard_tb.sv
module cmd_spacing_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cfg_word;
  logic [1:0]  mem_kind;
  logic        eight_bank;
  logic        req_valid;
  logic [2:0]  req_op;
  logic        req_ready;
  logic        iss_valid;
  logic [2:0]  iss_op;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model state
  int m_kind, m_lm, m_upd, m_wl, m_win;
  bit m_eight;
  int cyc = 0;
  bit have_lm, have_wl;
  int t_lm, t_wl;
  int act_t [4];
  int n_act;
  bit exp_iss;
  logic [2:0] exp_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_spacing_guard dut_i (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .mem_kind(mem_kind),
    .eight_bank(eight_bank), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .iss_valid(iss_valid), .iss_op(iss_op)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int lm_ref(input int f, input int k);
    case (k)
      0: return f + 4;
      1, 2: return f + 8;
      default: return f;
    endcase
  endfunction

  function automatic int upd_ref(input int c, input int k);
    if (k == 1) return 24 + ((c > 6) ? 6 : c);
    if (k == 0) return 12 + ((c > 5) ? 5 : c);
    return 0;
  endfunction

  function automatic bit ready_ref(input logic [2:0] op);
    bit ok = 1;
    bit lmop = (op == 3'd2) || (op == 3'd3);
    if (have_lm && (cyc - t_lm) < m_lm) ok = 0;
    if (have_lm && !lmop && (cyc - t_lm) < m_upd) ok = 0;
    if (op == 3'd4 && have_wl && (cyc - t_wl) < m_wl) ok = 0;
    if (op == 3'd1 && m_eight && n_act >= 4 && (cyc - act_t[3]) < m_win) ok = 0;
    return ok;
  endfunction

  function automatic logic [31:0] make_cfg(input int wl, input int win, input int code,
                                           input int lm, input logic [31:0] junk);
    logic [31:0] w;
    w = (junk & 32'h8080F8E0);
    w[30:24] = wl[6:0];
    w[22:16] = win[6:0];
    w[10:8]  = code[2:0];
    w[4:0]   = lm[4:0];
    return w;
  endfunction

  task automatic apply_cfg(input int k, input bit eb, input int wl, input int win,
                           input int code, input int lm, input logic [31:0] junk);
    cfg_word   = make_cfg(wl, win, code, lm, junk);
    mem_kind   = k[1:0];
    eight_bank = eb;
  endtask

  task automatic sync_model(input int k, input bit eb, input int wl, input int win,
                            input int code, input int lm);
    m_kind = k; m_eight = eb; m_wl = wl; m_win = win;
    m_upd = upd_ref(code, k); m_lm = lm_ref(lm, k);
  endtask

  // One cycle: drive at negedge, check, then advance at posedge. Returns acceptance.
  task automatic step(input bit v, input logic [2:0] op, input string tag, output bit fired);
    bit exp_rdy;
    @(negedge clk);
    req_valid = v;
    req_op    = op;
    #1;
    check(iss_valid == exp_iss, "R8 issue pulse", iss_valid, exp_iss);
    if (exp_iss) check(iss_op == exp_op, "R8 issue opcode", iss_op, exp_op);
    exp_rdy = ready_ref(op);
    check(req_ready == exp_rdy, tag, req_ready, exp_rdy);
    fired = v && req_ready;
    @(posedge clk);
    if (fired) begin
      if (op == 3'd2 || op == 3'd3) begin have_lm = 1; t_lm = cyc; end
      if (op == 3'd3) begin have_wl = 1; t_wl = cyc; end
      if (op == 3'd1) begin
        for (int i = 3; i > 0; i--) act_t[i] = act_t[i-1];
        act_t[0] = cyc;
        if (n_act < 4) n_act++;
      end
    end
    exp_iss = fired;
    exp_op  = op;
    cyc++;
  endtask

  task automatic idle(input int n);
    bit f;
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, "R10 idle readiness", f);
  endtask

  task automatic wait_accept(input logic [2:0] op, input string tag, output int waited);
    bit f = 0;
    waited = 0;
    while (!f && waited < 400) begin
      step(1'b1, op, tag, f);
      if (!f) waited++;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit f;
    int w;
    logic [2:0] pend;
    bit pending;
    int seed_sink;
    seed_sink = $urandom(32'h5EED_0007);
    have_lm = 0; have_wl = 0; n_act = 0; exp_iss = 0; exp_op = '0;
    req_valid = 0; req_op = '0;
    cfg_word = 32'h5656041E; mem_kind = 2'd1; eight_bank = 1'b1;
    sync_model(1, 1, 8'h56, 8'h56, 4, 5'h1E);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1: reset state, every opcode ready
    for (int op = 0; op < 8; op++) step(1'b0, op[2:0], "R1 ready after reset", f);

    // R6: eight banks off, back-to-back activates never stall
    apply_cfg(1, 0, 10, 40, 0, 0, '0); sync_model(1, 0, 10, 40, 0, 0); idle(5);
    for (int i = 0; i < 6; i++) step(1'b1, 3'd1, "R6 activate unrestricted", f);

    // R5: eight banks on, fifth activate held until window passes
    idle(200);
    apply_cfg(1, 1, 10, 20, 0, 0, '0); sync_model(1, 1, 10, 20, 0, 0); idle(5);
    for (int i = 0; i < 4; i++) step(1'b1, 3'd1, "R5 first four activates", f);
    wait_accept(3'd1, "R5 fifth activate", w);
    check(w == 16, "R5 fifth activate stall", w, 16);

    // R3: DDR4, ordinary command after load-mode waits update delay (code 7 -> 30)
    idle(200);
    apply_cfg(1, 1, 10, 20, 7, 2, '0); sync_model(1, 1, 10, 20, 7, 2); idle(5);
    step(1'b1, 3'd2, "R3 load-mode accepted", f);
    wait_accept(3'd0, "R3 update delay", w);
    check(w == 29, "R3 DDR4 capped code wait", w, 29);

    // R4: DDR3 code 7 -> 17, load-mode to load-mode governed by field+4
    idle(200);
    apply_cfg(0, 1, 10, 20, 7, 3, '0); sync_model(0, 1, 10, 20, 7, 3); idle(5);
    step(1'b1, 3'd2, "R4 load-mode accepted", f);
    wait_accept(3'd2, "R2 DDR3 load-mode pair", w);
    check(w == 6, "R2 DDR3 offset wait", w, 6);
    wait_accept(3'd0, "R4 DDR3 update delay", w);
    check(w == 16, "R4 DDR3 capped code wait", w, 16);

    // R7: LPDDR4, leveling strobe waits only the leveling delay
    idle(200);
    apply_cfg(3, 1, 25, 20, 5, 0, '0); sync_model(3, 1, 25, 20, 5, 0); idle(5);
    step(1'b1, 3'd3, "R7 leveling load accepted", f);
    wait_accept(3'd4, "R7 strobe wait", w);
    check(w == 24, "R7 leveling delay", w, 24);

    // R9: change config while a gap runs; old values still govern
    idle(200);
    apply_cfg(1, 1, 10, 20, 6, 20, '0); sync_model(1, 1, 10, 20, 6, 20); idle(5);
    step(1'b1, 3'd2, "R9 load-mode accepted", f);
    apply_cfg(1, 1, 10, 20, 0, 0, '0);
    wait_accept(3'd2, "R9 frozen config", w);
    check(w == 27, "R9 old load-mode gap", w, 27);
    idle(200);
    sync_model(1, 1, 10, 20, 0, 0);
    step(1'b1, 3'd2, "R9 new config load-mode", f);
    wait_accept(3'd2, "R9 new gap", w);
    check(w == 7, "R9 new load-mode gap", w, 7);

    // R2/R10: random traffic across all memory types, reserved bits noisy
    for (int ph = 0; ph < 8; ph++) begin
      int k = ph % 4;
      bit eb = (ph % 3) != 1;
      int wl = $urandom % 60, win = 2 + $urandom % 40, code = $urandom % 8, lm = $urandom % 32;
      idle(200);
      apply_cfg(k, eb, wl, win, code, lm, $urandom);
      sync_model(k, eb, wl, win, code, lm);
      idle(3);
      pending = 0; pend = '0;
      for (int i = 0; i < 700; i++) begin
        bit v;
        if (pending) v = 1;
        else begin
          int r = $urandom % 10;
          v = ($urandom % 5) != 0;
          pend = (r < 4) ? 3'd1 : (r == 4) ? 3'd2 : (r == 5) ? 3'd3 :
                 (r < 8) ? 3'd4 : ((r == 8) ? 3'd0 : 3'd6);
        end
        step(v, pend, "R10 random ready vs model", f);
        pending = v && !f;
      end
    end

    idle(2);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule